// File: doc/BRIEF.md
# Function Address Decoder with Compare and Mask Registers

This block decides, once per clock, whether a backplane bus access falls inside one of several address windows that a slave card exposes, and which window it falls into. Each window (a "function") is defined at build time by an address mask and by a bitmap of allowed address-modifier codes. At run time, software places the window by writing a compare word holding a base address and, optionally, the modifier code the window answers to. The decoder takes the 32-bit access address, the 6-bit address modifier and the compare words. It reports a hit flag, the number of the winning function, and the local address, which is the access address with every decoded (mask) bit cleared.

Functions are independent, so a card that must answer in two address spaces or to two transfer kinds (for example a 24-bit and a 32-bit space, or single and block transfers) uses one function per case. A function whose mask is zero is removed from the hardware. When several functions match, the lowest-numbered one wins. Outputs are registered and appear one clock after the inputs are sampled.

Top module: `vdec_top`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `hit_o` is 0, `func_o` is 0 and `local_addr_o` is 0, whatever the inputs are.
- R2: A function matches only when the access address and bits 31..8 of its compare word agree on every bit that is set in its mask. Address bits outside the mask have no effect on the match.
- R3: Only modifier codes 0x08 to 0x0F and 0x38 to 0x3F can produce a hit. A capability bit set for any other code is ignored.
- R4: A function matches only when bit number `am` of its capability bitmap (bit index equals the 6-bit modifier value) is set.
- R5: A function whose mask is all zero never matches, whatever its compare word and capability bitmap hold.
- R6: With the decode-modifier option on, a function matches only when the access modifier equals bits 7..2 of its compare word. With the option off, those bits are not checked.
- R7: When more than one function matches, `func_o` reports the lowest-numbered matching function.
- R8: On a hit, `local_addr_o` equals the access address with the winning function's mask bits cleared. On a miss, `func_o` and `local_addr_o` are 0.
- R9: While the module-enable input is 0, no access produces a hit.
- R10: The outputs reflect the inputs sampled at the previous rising clock edge. A change of the inputs does not reach the outputs before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_n_i | input | 1 | Synchronous reset, active low |
| mod_en_i | input | 1 | Module enable. When 0, every match is suppressed |
| vme_addr_i | input | 32 | Access address |
| vme_am_i | input | 6 | Access address-modifier code |
| ader_i | input | 32*NFUNC | Compare words, function n in bits 32n+31..32n. Bits 31..8 hold the base address and bits 7..2 hold the modifier code |
| hit_o | output | 1 | Some function matched the previous sample |
| func_o | output | clog2(NFUNC) | Number of the winning function |
| local_addr_o | output | 32 | Access address with the decoded bits cleared |

## Verification
The hardest case to reach from the ports is an access that several functions claim at once. In that case the priority order and the mask of the winning function, not the mask of a losing one, must shape the local address. The default build gives one function a narrower mask nested inside a wider function's window. The stimulus then places an address in the overlap, so both functions match and only the lower number should win. The same overlap is reused with modifier codes that one function allows and the other does not, so that the winner changes. A second instance with modifier decoding turned off runs beside the first on the same inputs, which separates the stored-code check from the capability check. An extra capability bit at an illegal code, and a disabled function with a matching compare word, confirm that neither can produce a hit.

// File: rtl/vdec_pkg.sv
package vdec_pkg;

    localparam int ADDR_W      = 32;
    localparam int AM_W        = 6;
    localparam int AM_CODES    = 1 << AM_W;
    localparam int CMP_AM_LSB  = 2;
    localparam int MASK_LSB    = 8;

    // Only address bits above MASK_LSB may take part in decoding.
    localparam logic [ADDR_W-1:0] MASK_KEEP = {{(ADDR_W-MASK_LSB){1'b1}}, {MASK_LSB{1'b0}}};

    // Modifier codes that a capability bitmap may enable.
    function automatic logic [AM_CODES-1:0] legal_am_map();
        logic [AM_CODES-1:0] m;
        m = '0;
        for (int a = 0; a < AM_CODES; a++) begin
            if ((a >= 'h08 && a <= 'h0F) || (a >= 'h38 && a <= 'h3F)) begin
                m[a] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/vdec_slot.sv
module vdec_slot
    import vdec_pkg::*;
#(
    parameter logic [ADDR_W-1:0]   MASK      = '0,
    parameter logic [AM_CODES-1:0] AMCAP     = '0,
    parameter bit                  DECODE_AM = 1'b1
) (
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [AM_W-1:0]   am_i,
    input  logic [ADDR_W-1:0] cmp_i,
    output logic              match_o
);

    localparam logic [ADDR_W-1:0]   EFF_MASK = MASK & MASK_KEEP;
    localparam logic [AM_CODES-1:0] EFF_CAP  = AMCAP & legal_am_map();

    generate
        if (EFF_MASK == '0) begin : g_off
            logic unused_inputs;
            assign unused_inputs = ^{en_i, addr_i, am_i, cmp_i};
            assign match_o = 1'b0;
        end else begin : g_on
            logic addr_ok;
            logic cap_ok;
            logic code_ok;

            assign addr_ok = ((addr_i ^ cmp_i) & EFF_MASK) == '0;
            assign cap_ok  = EFF_CAP[am_i];

            if (DECODE_AM) begin : g_code
                assign code_ok = cmp_i[CMP_AM_LSB +: AM_W] == am_i;
            end else begin : g_nocode
                assign code_ok = 1'b1;
            end

            assign match_o = en_i & addr_ok & cap_ok & code_ok;
        end
    endgenerate

endmodule

// File: rtl/vdec_prio.sv
module vdec_prio #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);

    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        // Scan downward so the lowest requesting index is kept last.
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = W'(i);
            end
        end
    end

endmodule

// File: rtl/vdec_top.sv
module vdec_top
    import vdec_pkg::*;
#(
    parameter int NFUNC     = 8,
    parameter bit DECODE_AM = 1'b1,
    parameter logic [NFUNC-1:0][ADDR_W-1:0] FUNC_MASK = {
        32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
        32'h0000_0000, 32'hFFFF_0000, 32'hFFF0_0000, 32'hFF00_0000
    },
    parameter logic [NFUNC-1:0][AM_CODES-1:0] FUNC_AMCAP = {
        64'h0, 64'h0, 64'h0, 64'h0,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'hFF00_0200_0000_FF00,
        64'hFF00_0000_0000_0000,
        64'h0000_0000_0000_FF00
    }
) (
    input  logic                      clk_i,
    input  logic                      rst_n_i,
    input  logic                      mod_en_i,
    input  logic [ADDR_W-1:0]         vme_addr_i,
    input  logic [AM_W-1:0]           vme_am_i,
    input  logic [NFUNC*ADDR_W-1:0]   ader_i,
    output logic                      hit_o,
    output logic [$clog2(NFUNC)-1:0]  func_o,
    output logic [ADDR_W-1:0]         local_addr_o
);

    localparam int IDX_W = $clog2(NFUNC);

    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  func;
        logic [ADDR_W-1:0] laddr;
    } dec_state_t;

    dec_state_t        st_d;
    dec_state_t        st_q;
    logic [NFUNC-1:0]  match;
    logic              any_hit;
    logic [IDX_W-1:0]  win_idx;
    logic [ADDR_W-1:0] mask_sel;

    generate
        for (genvar f = 0; f < NFUNC; f++) begin : g_func
            vdec_slot #(
                .MASK      (FUNC_MASK[f]),
                .AMCAP     (FUNC_AMCAP[f]),
                .DECODE_AM (DECODE_AM)
            ) u_slot (
                .en_i    (mod_en_i),
                .addr_i  (vme_addr_i),
                .am_i    (vme_am_i),
                .cmp_i   (ader_i[f*ADDR_W +: ADDR_W]),
                .match_o (match[f])
            );
        end
    endgenerate

    vdec_prio #(
        .N (NFUNC)
    ) u_prio (
        .req_i (match),
        .any_o (any_hit),
        .idx_o (win_idx)
    );

    always_comb begin
        mask_sel = '0;
        for (int i = 0; i < NFUNC; i++) begin
            if (win_idx == IDX_W'(i)) begin
                mask_sel = FUNC_MASK[i] & MASK_KEEP;
            end
        end

        st_d = '0;
        if (any_hit) begin
            st_d.hit   = 1'b1;
            st_d.func  = win_idx;
            st_d.laddr = vme_addr_i & ~mask_sel;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o        = st_q.hit;
    assign func_o       = st_q.func;
    assign local_addr_o = st_q.laddr;

endmodule

// File: rtl/vdec_chk.sv
module vdec_chk
    import vdec_pkg::*;
#(
    parameter int NFUNC = 8,
    parameter logic [NFUNC-1:0][ADDR_W-1:0] FUNC_MASK = '0
) (
    input logic                      clk_i,
    input logic                      rst_n_i,
    input logic                      mod_en_i,
    input logic [ADDR_W-1:0]         vme_addr_i,
    input logic [AM_W-1:0]           vme_am_i,
    input logic [NFUNC*ADDR_W-1:0]   ader_i,
    input logic                      hit_o,
    input logic [$clog2(NFUNC)-1:0]  func_o,
    input logic [ADDR_W-1:0]         local_addr_o
);

    localparam logic [AM_CODES-1:0] LEGAL = legal_am_map();

    logic [ADDR_W-1:0]       addr_p;
    logic [AM_W-1:0]         am_p;
    logic [NFUNC*ADDR_W-1:0] cmp_p;
    logic                    en_p;
    logic [ADDR_W-1:0]       win_mask;
    logic [ADDR_W-1:0]       win_cmp;

    always_ff @(posedge clk_i) begin
        addr_p <= vme_addr_i;
        am_p   <= vme_am_i;
        cmp_p  <= ader_i;
        en_p   <= mod_en_i;
    end

    always_comb begin
        win_mask = '0;
        win_cmp  = '0;
        for (int i = 0; i < NFUNC; i++) begin
            if (int'(func_o) == i) begin
                win_mask = FUNC_MASK[i] & MASK_KEEP;
                win_cmp  = cmp_p[i*ADDR_W +: ADDR_W];
            end
        end
    end

    AST_OFF_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !en_p |-> !hit_o);  // R9

    AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !hit_o |-> (func_o == '0 && local_addr_o == '0));  // R8

    AST_LADDR_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        hit_o |-> local_addr_o == (addr_p & ~win_mask));  // R8

    AST_MASKED_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        hit_o |-> ((addr_p ^ win_cmp) & win_mask) == '0);  // R2

    AST_AM_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        hit_o |-> LEGAL[am_p]);  // R3

endmodule

bind vdec_top vdec_chk #(
    .NFUNC     (NFUNC),
    .FUNC_MASK (FUNC_MASK)
) u_chk (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .mod_en_i     (mod_en_i),
    .vme_addr_i   (vme_addr_i),
    .vme_am_i     (vme_am_i),
    .ader_i       (ader_i),
    .hit_o        (hit_o),
    .func_o       (func_o),
    .local_addr_o (local_addr_o)
);

// File: tb/vdec_top_test.sv
module vdec_top_test;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         en;
    logic [31:0]  addr;
    logic [5:0]   am;
    logic [255:0] ader;

    logic         m_hit;
    logic [2:0]   m_func;
    logic [31:0]  m_laddr;
    logic         n_hit;
    logic [2:0]   n_func;
    logic [31:0]  n_laddr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vdec_top #(.DECODE_AM(1'b1)) uut (
        .clk_i(clk), .rst_n_i(rst_n), .mod_en_i(en), .vme_addr_i(addr),
        .vme_am_i(am), .ader_i(ader), .hit_o(m_hit), .func_o(m_func),
        .local_addr_o(m_laddr)
    );

    vdec_top #(.DECODE_AM(1'b0)) uut_noam (
        .clk_i(clk), .rst_n_i(rst_n), .mod_en_i(en), .vme_addr_i(addr),
        .vme_am_i(am), .ader_i(ader), .hit_o(n_hit), .func_o(n_func),
        .local_addr_o(n_laddr)
    );

    typedef struct packed {
        int          req;
        logic        en;
        logic [31:0] addr;
        logic [5:0]  am;
        logic        mh;
        logic [2:0]  mf;
        logic [31:0] ml;
        logic        nh;
        logic [2:0]  nf;
        logic [31:0] nl;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2,  1'b1, 32'h1200_5678, 6'h09, 1'b1, 3'd0, 32'h0000_5678, 1'b1, 3'd0, 32'h0000_5678}, // R2 R8
        '{7,  1'b1, 32'h1234_5678, 6'h09, 1'b1, 3'd0, 32'h0034_5678, 1'b1, 3'd0, 32'h0034_5678}, // R7 overlap
        '{2,  1'b1, 32'h0031_2345, 6'h39, 1'b1, 3'd1, 32'h0001_2345, 1'b1, 3'd1, 32'h0001_2345}, // R2
        '{6,  1'b1, 32'h0031_2345, 6'h3D, 1'b0, 3'd0, 32'h0,         1'b1, 3'd1, 32'h0001_2345}, // R6
        '{2,  1'b1, 32'h1300_5678, 6'h09, 1'b0, 3'd0, 32'h0,         1'b0, 3'd0, 32'h0},         // R2 miss
        '{6,  1'b1, 32'h1200_5678, 6'h0D, 1'b0, 3'd0, 32'h0,         1'b1, 3'd0, 32'h0000_5678}, // R6
        '{4,  1'b1, 32'h1234_5678, 6'h39, 1'b0, 3'd0, 32'h0,         1'b1, 3'd2, 32'h0000_5678}, // R4
        '{3,  1'b1, 32'h1234_5678, 6'h29, 1'b0, 3'd0, 32'h0,         1'b0, 3'd0, 32'h0},         // R3
        '{5,  1'b1, 32'h0000_0000, 6'h0D, 1'b0, 3'd0, 32'h0,         1'b0, 3'd0, 32'h0},         // R5
        '{4,  1'b1, 32'h0031_2345, 6'h09, 1'b0, 3'd0, 32'h0,         1'b0, 3'd0, 32'h0},         // R4
        '{9,  1'b0, 32'h1200_5678, 6'h09, 1'b0, 3'd0, 32'h0,         1'b0, 3'd0, 32'h0},         // R9
        '{7,  1'b1, 32'h1234_5678, 6'h0D, 1'b0, 3'd0, 32'h0,         1'b1, 3'd0, 32'h0034_5678}  // R7
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        en   = v.en;
        addr = v.addr;
        am   = v.am;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // Compare words: bits 31..8 base, bits 7..2 modifier code
        ader = '0;
        ader[0*32 +: 32] = 32'h1200_0024;  // base 0x12xxxxxx, code 0x09
        ader[1*32 +: 32] = 32'h0030_00E4;  // base 0x003xxxxx, code 0x39
        ader[2*32 +: 32] = 32'h1234_0024;  // base 0x1234xxxx, code 0x09
        ader[3*32 +: 32] = 32'h0000_0034;  // disabled function, code 0x0D

        rst_n = 1'b0;
        apply(VEC[0]);
        repeat (3) @(negedge clk);
        // R1: outputs cleared in reset despite a matching access
        check("R1 hit",   {31'd0, m_hit}, 32'd0);
        check("R1 func",  {29'd0, m_func}, 32'd0);
        check("R1 laddr", m_laddr, 32'd0);
        rst_n = 1'b1;
        check("R1 first cycle hit", {31'd0, m_hit}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            @(negedge clk);
            check($sformatf("R%0d vec%0d main hit", VEC[i].req, i),   {31'd0, m_hit},  {31'd0, VEC[i].mh});
            check($sformatf("R%0d vec%0d main func", VEC[i].req, i),  {29'd0, m_func}, {29'd0, VEC[i].mf});
            check($sformatf("R%0d vec%0d main laddr", VEC[i].req, i), m_laddr,         VEC[i].ml);
            check($sformatf("R%0d vec%0d noam hit", VEC[i].req, i),   {31'd0, n_hit},  {31'd0, VEC[i].nh});
            check($sformatf("R%0d vec%0d noam func", VEC[i].req, i),  {29'd0, n_func}, {29'd0, VEC[i].nf});
            check($sformatf("R%0d vec%0d noam laddr", VEC[i].req, i), n_laddr,         VEC[i].nl);
        end

        // R10: a new hitting access is not visible before the next edge
        @(negedge clk);
        apply(VEC[10]);
        @(negedge clk);
        check("R10 prior miss", {31'd0, m_hit}, 32'd0);
        apply(VEC[0]);
        #2;
        check("R10 no early hit", {31'd0, m_hit}, 32'd0);
        @(negedge clk);
        check("R10 hit after edge", {31'd0, m_hit}, 32'd1);
        check("R10 laddr after edge", m_laddr, 32'h0000_5678);

        // R9: dropping enable clears the hit on the following edge
        en = 1'b0;
        @(negedge clk);
        check("R9 enable low", {31'd0, m_hit}, 32'd0);
        check("R9 enable low noam", {31'd0, n_hit}, 32'd0);
        en = 1'b1;

        // R8: address bits below the mask pass through unchanged
        addr = 32'h12FF_FFFF;
        am   = 6'h0F;
        @(negedge clk);
        check("R8 noam laddr", n_laddr, 32'h00FF_FFFF);
        check("R8 main miss laddr", m_laddr, 32'd0);

        // R1: reset in the middle of a hit
        addr = 32'h1200_5678;
        am   = 6'h09;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset hit", {31'd0, m_hit}, 32'd0);
        check("R1 mid-run reset laddr", m_laddr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 recovered hit", {31'd0, m_hit}, 32'd1);

        finish_run();
    end

endmodule